// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address once a translation cache has missed. A single-cycle start pulse hands it the address. The walker picks one of two table roots and reads descriptors from memory, one word at a time, through a request/response port. It stops after one read when the first-level entry maps a whole region. It reads a second time when the first-level entry points to a second-level table.

The walker returns one of four block sizes: 4 KB, 64 KB, 1 MB, or 16 MB. The 16 MB form widens the physical address to 40 bits. Along with the address it returns the size code and an 8-bit attribute field taken from the final descriptor. If a descriptor is invalid, it returns a translation fault instead. Each result is announced by a one-cycle done pulse, and the result outputs keep their values until the next walk completes.

States: `ST_IDLE` (waiting for a start), `ST_L1_REQ` (issue the first-level read), `ST_L1_WAIT` (wait for it), `ST_L2_REQ` (issue the second-level read), `ST_L2_WAIT` (wait for it) and `ST_DONE` (announce the result). Transitions:
- IDLE→L1_REQ on start.
- L1_REQ→L1_WAIT always.
- L1_WAIT→L2_REQ when the response is a table pointer.
- L1_WAIT→DONE on any other response.
- L2_REQ→L2_WAIT always.
- L2_WAIT→DONE on the response.
- DONE→IDLE always.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `walk_busy`, `mem_req`, `walk_done` and `walk_fault` are all low.
- R2: `split_n` (0..7) selects how many of the top address bits are tested. If all of those bits are zero, root `tbl_base0` is used; otherwise `tbl_base1` is used. With `split_n` = 0, root 0 is always used.
- R3: The first-level read address is root + va[31:20]×4. Every read is a single-cycle `mem_req` pulse.
- R4: A first-level descriptor with bits[1:0]=10 and bit18=0 maps 1 MB. The physical address is {8'h00, desc[31:20], va[19:0]}, and size code is 2.
- R5: A first-level descriptor with bits[1:0]=10 and bit18=1 maps 16 MB. The physical address is {desc[23:19], desc[17:15], desc[31:24], va[23:0]}, and size code is 3.
- R6: A first-level descriptor with bits[1:0]=01 points to a second-level table at {desc[31:10], 10'b0}. That table is read at table + va[19:12]×4, so a page walk makes exactly two reads. A second-level descriptor with bits[1:0]=1x maps 4 KB: the physical address is {8'h00, desc[31:12], va[11:0]}, and size code is 0.
- R7: A second-level descriptor with bits[1:0]=01 maps 64 KB. The physical address is {8'h00, desc[31:16], va[15:0]}, and size code is 1.
- R8: A first-level descriptor with bits[1:0] of 00 or 11 ends the walk with `walk_fault` high. So does a second-level descriptor with bits[1:0]=00. In both cases pa, size and attributes are zero.
- R9: `walk_attr` equals bits[9:2] of the descriptor that ended the walk.
- R10: A start pulse that arrives while the walker is busy is ignored: no extra walk, and no extra result.
- R11: `walk_done` is a one-cycle pulse in the cycle after the final read response. The results stay unchanged until the next walk ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| walk_start | input | 1 | Start pulse; accepted only when idle |
| walk_va | input | 32 | Virtual address, captured on start |
| split_n | input | SPLIT_W | Count of top address bits tested for root selection |
| tbl_base0 | input | 32 | Root table address 0 |
| tbl_base1 | input | 32 | Root table address 1 |
| walk_busy | output | 1 | High from start until the done cycle |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Byte address of the requested descriptor |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| walk_done | output | 1 | Result pulse |
| walk_fault | output | 1 | Translation fault |
| walk_pa | output | 40 | Physical address |
| walk_size | output | 2 | Size code (0 4 KB, 1 64 KB, 2 1 MB, 3 16 MB) |
| walk_attr | output | 8 | Attribute bits from the final descriptor |

## Verification
A start at clock edge k raises `mem_req` in the cycle after k. `walk_done` comes one cycle after the final `mem_rvalid`. A one-read walk therefore ends latency + 3 cycles after start, and a two-read walk ends 2×latency + 5 cycles after start. Because memory latency is a bench variable, the monitor does not count cycles from the start. Instead it samples on the falling edge whenever `walk_done` is high, pops the expected item, and compares all fields. It also compares the number of memory reads made since the start. An assertion ties `walk_done` to a response one cycle earlier, and the runs are repeated with a longer latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int PA_W   = 40;
    localparam int ATTR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } page_size_t;

    typedef struct packed {
        logic              fault;
        logic              more;
        logic [31:0]       next_base;
        logic [PA_W-1:0]   pa;
        page_size_t        size;
        logic [ATTR_W-1:0] attr;
    } decode_t;
endpackage

// File: rtl/ptw_base_sel.sv
module ptw_base_sel #(
    parameter int SPLIT_W = 3,
    parameter int TOP_W   = (1 << SPLIT_W) - 1
) (
    input  logic [TOP_W-1:0]   va_top,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic [31:0]        base0,
    input  logic [31:0]        base1,
    output logic [31:0]        base
);
    logic use_hi;

    // va_top[TOP_W-1] is the address MSB; test split_n bits from there down
    always_comb begin
        use_hi = 1'b0;
        for (int i = 0; i < TOP_W; i++) begin
            if (i < int'(split_n) && va_top[TOP_W-1-i]) use_hi = 1'b1;
        end
        base = use_hi ? base1 : base0;
    end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
    import ptw_pkg::*;
(
    input  logic        level2,
    input  logic [31:0] desc,
    input  logic [23:0] va_low,
    output decode_t     res
);
    always_comb begin
        res = '0;
        if (!level2) begin
            unique case (desc[1:0])
                2'b01: begin
                    res.more      = 1'b1;
                    res.next_base = {desc[31:10], 10'b0};
                end
                2'b10: begin
                    res.attr = desc[9:2];
                    if (desc[18]) begin
                        res.size = SZ_16M;
                        res.pa   = {desc[23:19], desc[17:15], desc[31:24], va_low[23:0]};
                    end else begin
                        res.size = SZ_1M;
                        res.pa   = {8'h00, desc[31:20], va_low[19:0]};
                    end
                end
                default: res.fault = 1'b1;
            endcase
        end else begin
            unique case (desc[1:0])
                2'b01: begin
                    res.size = SZ_64K;
                    res.pa   = {8'h00, desc[31:16], va_low[15:0]};
                    res.attr = desc[9:2];
                end
                2'b10, 2'b11: begin
                    res.size = SZ_4K;
                    res.pa   = {8'h00, desc[31:12], va_low[11:0]};
                    res.attr = desc[9:2];
                end
                default: res.fault = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int SPLIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               walk_start,
    input  logic [31:0]        walk_va,
    input  logic [SPLIT_W-1:0] split_n,
    input  logic [31:0]        tbl_base0,
    input  logic [31:0]        tbl_base1,
    output logic               walk_busy,
    output logic               mem_req,
    output logic [31:0]        mem_addr,
    input  logic               mem_rvalid,
    input  logic [31:0]        mem_rdata,
    output logic               walk_done,
    output logic               walk_fault,
    output logic [39:0]        walk_pa,
    output logic [1:0]         walk_size,
    output logic [7:0]         walk_attr
);
    localparam int TOP_W = (1 << SPLIT_W) - 1;

    walk_state_t         state_q, state_d;
    logic [31:0]         va_q;
    logic [31:0]         l2_base_q;
    logic [31:0]         root_base;
    logic [31:0]         l1_addr, l2_addr;
    decode_t             dec;
    logic                fault_q;
    logic [PA_W-1:0]     pa_q;
    logic [1:0]          size_q;
    logic [ATTR_W-1:0]   attr_q;

    ptw_base_sel #(.SPLIT_W(SPLIT_W), .TOP_W(TOP_W)) u_base_sel (
        .va_top (va_q[31 -: TOP_W]),
        .split_n(split_n),
        .base0  (tbl_base0),
        .base1  (tbl_base1),
        .base   (root_base)
    );

    ptw_desc_decode u_decode (
        .level2(state_q == ST_L2_WAIT),
        .desc  (mem_rdata),
        .va_low(va_q[23:0]),
        .res   (dec)
    );

    assign l1_addr = root_base + {18'b0, va_q[31:20], 2'b00};
    assign l2_addr = l2_base_q + {22'b0, va_q[19:12], 2'b00};

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (walk_start) state_d = ST_L1_REQ;
            ST_L1_REQ:  state_d = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rvalid) state_d = dec.more ? ST_L2_REQ : ST_DONE;
            ST_L2_REQ:  state_d = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rvalid) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q      <= '0;
            l2_base_q <= '0;
            fault_q   <= 1'b0;
            pa_q      <= '0;
            size_q    <= '0;
            attr_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && walk_start) va_q <= walk_va;
            if (state_q == ST_L1_WAIT && mem_rvalid && dec.more) l2_base_q <= dec.next_base;
            if (mem_rvalid && ((state_q == ST_L1_WAIT && !dec.more) || state_q == ST_L2_WAIT)) begin
                fault_q <= dec.fault;
                pa_q    <= dec.pa;
                size_q  <= dec.size;
                attr_q  <= dec.attr;
            end
        end
    end

    // outputs
    always_comb begin
        walk_busy  = (state_q != ST_IDLE);
        mem_req    = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
        mem_addr   = (state_q == ST_L2_REQ) ? l2_addr : l1_addr;
        walk_done  = (state_q == ST_DONE);
        walk_fault = fault_q;
        walk_pa    = pa_q;
        walk_size  = size_q;
        walk_attr  = attr_q;
    end

    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    p_done_after_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> $past(mem_rvalid));

    p_pa_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rvalid |=> $stable(walk_pa));

    p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_done && walk_fault) |-> (walk_pa == '0 && walk_attr == '0));
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        walk_start = 1'b0;
    logic [31:0] walk_va = '0;
    logic [2:0]  split_n = 3'd2;
    logic [31:0] tbl_base0 = 32'h0000_4000;
    logic [31:0] tbl_base1 = 32'h0008_0000;
    logic        walk_busy, mem_req, walk_done, walk_fault;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [39:0] walk_pa;
    logic [1:0]  walk_size;
    logic [7:0]  walk_attr;

    int n_checks = 0;
    int n_fails  = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .walk_start(walk_start), .walk_va(walk_va),
        .split_n(split_n), .tbl_base0(tbl_base0), .tbl_base1(tbl_base1),
        .walk_busy(walk_busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .walk_done(walk_done),
        .walk_fault(walk_fault), .walk_pa(walk_pa), .walk_size(walk_size),
        .walk_attr(walk_attr)
    );

    // behavioural memory with fixed latency
    logic [31:0] mem [logic [31:0]];
    int          lat = 2;
    int          reads = 0;
    int          reads_at_start = 0;
    bit          pend = 1'b0;
    int          cnt = 0;
    logic [31:0] paddr = '0;

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_req) begin
            pend  <= 1'b1;
            paddr <= mem_addr;
            cnt   <= lat;
            reads =  reads + 1;
        end else if (pend) begin
            if (cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(paddr) ? mem[paddr] : 32'h0;
                pend       <= 1'b0;
            end
            cnt <= cnt - 1;
        end
    end

    typedef struct {
        logic        fault;
        logic [39:0] pa;
        logic [1:0]  size;
        logic [7:0]  attr;
        int          nreads;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        end
    endtask

    // monitor: pops an expected item on every done pulse
    always @(negedge clk) begin
        if (rst_n && walk_done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 64'(walk_pa), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(walk_fault == e.fault, e.tag, "fault", 64'(walk_fault), 64'(e.fault));
                check(walk_pa == e.pa, e.tag, "pa", 64'(walk_pa), 64'(e.pa));
                check(walk_size == e.size, e.tag, "size", 64'(walk_size), 64'(e.size));
                check(walk_attr == e.attr, "R9", "attr", 64'(walk_attr), 64'(e.attr));
                check((reads - reads_at_start) == e.nreads, e.tag, "reads",
                      64'(reads - reads_at_start), 64'(e.nreads));
            end
        end
    end

    task automatic walk(input logic [31:0] va, input logic [2:0] n, input logic fault,
                        input logic [39:0] pa, input logic [1:0] size, input logic [7:0] attr,
                        input int nreads, input string tag);
        exp_t e;
        @(negedge clk);
        split_n        = n;
        reads_at_start = reads;
        e.fault = fault; e.pa = pa; e.size = size; e.attr = attr;
        e.nreads = nreads; e.tag = tag;
        exp_q.push_back(e);
        walk_va    = va;
        walk_start = 1'b1;
        @(negedge clk);
        walk_start = 1'b0;
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 64'(n_checks), 64'h0);
        summary();
        $finish;
    end

    initial begin
        // table contents
        mem[32'h0000_448C] = 32'hABC0_016A;  // 1 MB, attr 5A
        mem[32'h0008_31D8] = 32'h9EB7_80CE;  // 16 MB, ext B7, base 9E, attr 33
        mem[32'h0000_4004] = 32'h0002_0401;  // pointer to 0x20400
        mem[32'h0002_040C] = 32'h7654_3086;  // 4 KB (10), attr 21
        mem[32'h0002_0410] = 32'h1234_503F;  // 4 KB (11), attr 0F
        mem[32'h0008_1008] = 32'h0003_0001;  // pointer to 0x30000
        mem[32'h0003_0024] = 32'hCAFE_0111;  // 64 KB, attr 44
        mem[32'h0000_40C0] = 32'h1230_0003;  // reserved type 11
        mem[32'h0000_71D8] = 32'h5550_0006;  // 1 MB, attr 01
        mem[32'h0000_4048] = 32'h0F00_0002;  // 1 MB
        mem[32'h0008_0088] = 32'h0E10_0002;  // 1 MB

        repeat (3) @(negedge clk);
        // R1 reset state
        check(walk_busy == 1'b0, "R1", "busy", 64'(walk_busy), 64'h0);
        check(mem_req == 1'b0, "R1", "mem_req", 64'(mem_req), 64'h0);
        check(walk_done == 1'b0, "R1", "done", 64'(walk_done), 64'h0);
        check(walk_fault == 1'b0, "R1", "fault", 64'(walk_fault), 64'h0);
        rst_n = 1'b1;

        // R3 R4: section through root 0
        walk(32'h1234_5678, 3'd2, 1'b0, 40'h00_ABC4_5678, 2'd2, 8'h5A, 1, "R4");
        // R5: supersection through root 1
        walk(32'hC765_4321, 3'd2, 1'b0, 40'hB7_9E65_4321, 2'd3, 8'h33, 1, "R5");
        // R6: small pages, both encodings
        walk(32'h0010_3ABC, 3'd2, 1'b0, 40'h00_7654_3ABC, 2'd0, 8'h21, 2, "R6");
        walk(32'h0010_4DEF, 3'd2, 1'b0, 40'h00_1234_5DEF, 2'd0, 8'h0F, 2, "R6");
        // R7: large page through root 1
        walk(32'h4020_9876, 3'd2, 1'b0, 40'h00_CAFE_9876, 2'd1, 8'h44, 2, "R7");
        // R8: faults at level one (00, 11) and level two (00)
        walk(32'h2000_0000, 3'd2, 1'b1, 40'h0, 2'd0, 8'h00, 1, "R8");
        walk(32'h0300_0000, 3'd2, 1'b1, 40'h0, 2'd0, 8'h00, 1, "R8");
        walk(32'h0010_5000, 3'd2, 1'b1, 40'h0, 2'd0, 8'h00, 2, "R8");
        // R2: split 0 forces root 0; split 7 edges
        walk(32'hC765_4321, 3'd0, 1'b0, 40'h00_5555_4321, 2'd2, 8'h01, 1, "R2");
        walk(32'h0123_4567, 3'd7, 1'b0, 40'h00_0F03_4567, 2'd2, 8'h00, 1, "R2");
        walk(32'h0223_4567, 3'd7, 1'b0, 40'h00_0E13_4567, 2'd2, 8'h00, 1, "R2");

        // R11: longer memory latency, result held afterwards
        lat = 5;
        walk(32'h4020_9876, 3'd2, 1'b0, 40'h00_CAFE_9876, 2'd1, 8'h44, 2, "R11");
        walk(32'h1234_5678, 3'd2, 1'b0, 40'h00_ABC4_5678, 2'd2, 8'h5A, 1, "R11");
        repeat (4) @(negedge clk);
        check(walk_pa == 40'h00_ABC4_5678, "R11", "held pa", 64'(walk_pa), 64'h00ABC45678);
        lat = 2;

        // R10: start while busy is ignored
        begin
            exp_t e;
            @(negedge clk);
            split_n = 3'd2;
            reads_at_start = reads;
            e.fault = 1'b0; e.pa = 40'h00_ABC4_5678; e.size = 2'd2; e.attr = 8'h5A;
            e.nreads = 1; e.tag = "R10";
            exp_q.push_back(e);
            walk_va = 32'h1234_5678; walk_start = 1'b1;
            @(negedge clk);
            walk_va = 32'hC765_4321;             // busy now
            @(negedge clk);
            walk_start = 1'b0;
            wait (exp_q.size() == 0);
            repeat (12) @(negedge clk);
            check(walk_busy == 1'b0, "R10", "busy after ignored start", 64'(walk_busy), 64'h0);
            check(walk_pa == 40'h00_ABC4_5678, "R10", "pa after ignored start",
                  64'(walk_pa), 64'h00ABC45678);
        end

        summary();
        $finish;
    end
endmodule